// File: doc/BRIEF.md
# Message Queue Doorbell Unit

This block is a messaging unit between a host and a local processor. It holds four circular lists of 32-bit message frame addresses in a small internal memory. The lists are the inbound free list, the inbound post list, the outbound post list and the outbound free list. The host reaches the lists through two queue windows.

A host read of the inbound window takes a free frame from the inbound free list. A host write to the same window posts a frame to the inbound post list. The outbound window does the opposite pairing: a read takes a posted frame from the outbound post list, and a write returns a free frame to the outbound free list.

The local processor works through a second register port. On this port it can program every head and tail pointer and push to or pop from any list. It also owns a mask and a status word. An active-low interrupt tells the local side that inbound posts are waiting.

Both ports are request streams carrying an address, a write flag and write data. The host stream is always accepted, so it has no ready signal. The local stream has a ready signal that is low in any cycle where the host is also requesting. The local request is held until the first cycle in which ready is high. A read returns its data with a response valid one cycle after the request is accepted. Writes produce no response.

Top module: `mq_doorbell_unit`

## Requirements
- R1: After reset all pointers are 0, all lists are empty, the mask register reads 32'h8, the status register reads 0 and `s_irq_n` is high.
- R2: A host read of address 8'h40 returns the entry at the inbound free list head and advances that head by one.
- R3: A host write to address 8'h40 stores the data at the inbound post list tail and advances that tail. The local side removes posts by reading its window at 8'h84, which returns the inbound post list head entry and advances that head.
- R4: A host read of 8'h44 pops the head of the outbound post list. A host write to 8'h44 pushes to the tail of the outbound free list.
- R5: Local accesses to 8'h40 and 8'h44 read 0 and change no list.
- R6: The local side writes and reads pointers at 8'h60 + 8*list + 4*sel, where list is 0 inbound free, 1 inbound post, 2 outbound post or 3 outbound free, and sel is 0 for head or 1 for tail. The value is in bits 3:0 and the other bits read 0.
- R7: The local register at 8'h3C holds the inbound post mask in bit 3, reset value 1. All its other bits read 0.
- R8: `s_irq_n` is low exactly while the inbound post list is non-empty and the mask bit is 0.
- R9: Each list holds 16 slots with 4-bit pointers that wrap from 15 to 0. A list is empty when head equals tail and full when tail+1 equals head, so it holds at most 15 entries.
- R10: A read-pop from an empty list returns 32'hFFFF_FFFF and leaves the head unchanged.
- R11: A push to a full list is dropped and sets a sticky overflow bit for that list, in bit [list] of the local status register at 8'h90. Writing 1 to that bit clears it. Status bit 4 reads 1 while the inbound post list is non-empty.
- R12: When both ports request in the same cycle, the host is served and `s_ready` is low. Read data appears with its response valid on the cycle after acceptance, and at most one response is issued per cycle.
- R13: The local window at 8'h80 + 4*list pops that list's head on a read and pushes to its tail on a write, with the empty and full rules of R10 and R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p_valid | input | 1 | Host request valid, always accepted |
| p_write | input | 1 | Host request is a write |
| p_addr | input | 8 | Host byte address |
| p_wdata | input | 32 | Host write data |
| p_rvalid | output | 1 | Host read response valid |
| p_rdata | output | 32 | Host read data |
| s_valid | input | 1 | Local request valid |
| s_ready | output | 1 | Local request accepted this cycle |
| s_write | input | 1 | Local request is a write |
| s_addr | input | 8 | Local byte address |
| s_wdata | input | 32 | Local write data |
| s_rvalid | output | 1 | Local read response valid |
| s_rdata | output | 32 | Local read data |
| s_irq_n | output | 1 | Inbound post interrupt, active low |

## Verification
The hardest conditions to reach from the ports are a full list and a pointer wrap. Each one needs a long run of pushes with no pop in between. The stimulus programs the inbound free list pointers to slot 14 and pushes across the wrap point. It then writes sixteen posts in a row from the host, so the last one must be dropped and must raise the sticky overflow bit. After that the local side drains all fifteen stored posts and confirms that the dropped frame never appears. A separate step drives both ports in the same cycle to show the back-pressure on the local stream.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned MQ_AW = 8;

  typedef enum logic [2:0] {
    K_NONE,
    K_POP,
    K_PUSH,
    K_PTR,
    K_MASK,
    K_STAT
  } mq_kind_e;

  localparam logic [1:0] L_IN_FREE  = 2'd0;
  localparam logic [1:0] L_IN_POST  = 2'd1;
  localparam logic [1:0] L_OUT_POST = 2'd2;
  localparam logic [1:0] L_OUT_FREE = 2'd3;

  localparam logic [MQ_AW-1:0] A_MASK = 8'h3C;
  localparam logic [MQ_AW-1:0] A_INQ  = 8'h40;
  localparam logic [MQ_AW-1:0] A_OUTQ = 8'h44;
  localparam logic [MQ_AW-1:0] A_STAT = 8'h90;
endpackage

// File: rtl/mq_decode.sv
module mq_decode
  import mq_pkg::*;
(
  input  logic             from_host,
  input  logic             is_write,
  input  logic [MQ_AW-1:0] addr,
  output mq_kind_e         kind,
  output logic [1:0]       list,
  output logic             tail_sel
);
  always_comb begin
    kind     = K_NONE;
    list     = 2'd0;
    tail_sel = 1'b0;
    if (from_host) begin
      if (addr == A_INQ) begin
        kind = is_write ? K_PUSH : K_POP;
        list = is_write ? L_IN_POST : L_IN_FREE;
      end else if (addr == A_OUTQ) begin
        kind = is_write ? K_PUSH : K_POP;
        list = is_write ? L_OUT_FREE : L_OUT_POST;
      end
    end else begin
      if (addr == A_MASK) begin
        kind = K_MASK;
      end else if (addr == A_STAT) begin
        kind = K_STAT;
      end else if (addr[7:5] == 3'b011 && addr[1:0] == 2'b00) begin
        kind     = K_PTR;
        list     = addr[4:3];
        tail_sel = addr[2];
      end else if (addr[7:4] == 4'h8 && addr[1:0] == 2'b00) begin
        kind = is_write ? K_PUSH : K_POP;
        list = addr[3:2];
      end
    end
  end
endmodule

// File: rtl/mq_ptr_pair.sv
module mq_ptr_pair #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_req,
  input  logic             push_req,
  input  logic             set_head,
  input  logic             set_tail,
  input  logic [PTR_W-1:0] set_val,
  input  logic             ovf_clr,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             empty,
  output logic             full,
  output logic             pop_ok,
  output logic             push_ok,
  output logic             ovf
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  assign empty   = (head == tail);
  assign full    = ((tail + ONE) == head);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      ovf  <= 1'b0;
    end else begin
      if (set_head)     head <= set_val;
      else if (pop_ok)  head <= head + ONE;
      if (set_tail)     tail <= set_val;
      else if (push_ok) tail <= tail + ONE;
      if (push_req && full) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  a_r10_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !set_head) |=> $stable(head));
  a_r11_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> ovf);
  a_r9_tail_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !set_tail) |=> (tail == $past(tail) + ONE));
endmodule

// File: rtl/mq_irq.sv
module mq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_we,
  input  logic mask_wval,
  input  logic pending,
  output logic mask,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= 1'b1;
    else if (mask_we) mask <= mask_wval;
  end

  assign irq_n = ~(pending & ~mask);
endmodule

// File: rtl/mq_doorbell_unit.sv
module mq_doorbell_unit
  import mq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_valid,
  input  logic              p_write,
  input  logic [MQ_AW-1:0]  p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic              p_rvalid,
  output logic [DATA_W-1:0] p_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_write,
  input  logic [MQ_AW-1:0]  s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_rvalid,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_irq_n
);
  localparam int unsigned N_LISTS = 4;
  localparam int unsigned LIST_W  = 2;
  localparam int unsigned DEPTH   = 1 << PTR_W;
  localparam int unsigned MEM_D   = N_LISTS * DEPTH;

  logic              acc, cur_wr;
  logic [MQ_AW-1:0]  cur_addr;
  logic [DATA_W-1:0] cur_wdata, rd_val;
  mq_kind_e          kind;
  logic [LIST_W-1:0] cur_list;
  logic              tail_sel, mask, pending;

  logic [PTR_W-1:0] head_a [N_LISTS];
  logic [PTR_W-1:0] tail_a [N_LISTS];
  logic [N_LISTS-1:0] empty_v, full_v, pop_ok_v, push_ok_v, ovf_v;
  logic [N_LISTS-1:0] pop_req_v, push_req_v, set_head_v, set_tail_v, ovf_clr_v;

  logic [DATA_W-1:0] mem [MEM_D];

  assign s_ready   = !p_valid;
  assign acc       = p_valid || s_valid;
  assign cur_wr    = p_valid ? p_write : s_write;
  assign cur_addr  = p_valid ? p_addr  : s_addr;
  assign cur_wdata = p_valid ? p_wdata : s_wdata;

  mq_decode u_dec (
    .from_host (p_valid),
    .is_write  (cur_wr),
    .addr      (cur_addr),
    .kind      (kind),
    .list      (cur_list),
    .tail_sel  (tail_sel)
  );

  for (genvar g = 0; g < N_LISTS; g++) begin : g_list
    localparam logic [LIST_W-1:0] IDX = LIST_W'(g);
    logic hit;
    assign hit           = acc && (cur_list == IDX);
    assign pop_req_v[g]  = hit && !cur_wr && (kind == K_POP);
    assign push_req_v[g] = hit &&  cur_wr && (kind == K_PUSH);
    assign set_head_v[g] = hit &&  cur_wr && (kind == K_PTR) && !tail_sel;
    assign set_tail_v[g] = hit &&  cur_wr && (kind == K_PTR) &&  tail_sel;
    assign ovf_clr_v[g]  = acc && cur_wr && (kind == K_STAT) && cur_wdata[g];

    mq_ptr_pair #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_req  (pop_req_v[g]),
      .push_req (push_req_v[g]),
      .set_head (set_head_v[g]),
      .set_tail (set_tail_v[g]),
      .set_val  (cur_wdata[PTR_W-1:0]),
      .ovf_clr  (ovf_clr_v[g]),
      .head     (head_a[g]),
      .tail     (tail_a[g]),
      .empty    (empty_v[g]),
      .full     (full_v[g]),
      .pop_ok   (pop_ok_v[g]),
      .push_ok  (push_ok_v[g]),
      .ovf      (ovf_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (|push_ok_v) mem[{cur_list, tail_a[cur_list]}] <= cur_wdata;
  end

  assign pending = !empty_v[L_IN_POST];

  mq_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (acc && cur_wr && (kind == K_MASK)),
    .mask_wval (cur_wdata[3]),
    .pending   (pending),
    .mask      (mask),
    .irq_n     (s_irq_n)
  );

  always_comb begin
    unique case (kind)
      K_POP:   rd_val = empty_v[cur_list] ? '1 : mem[{cur_list, head_a[cur_list]}];
      K_PTR:   rd_val = {{(DATA_W-PTR_W){1'b0}},
                         (tail_sel ? tail_a[cur_list] : head_a[cur_list])};
      K_MASK:  rd_val = {{(DATA_W-4){1'b0}}, mask, 3'b000};
      K_STAT:  rd_val = {{(DATA_W-N_LISTS-1){1'b0}}, pending, ovf_v};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rvalid <= 1'b0;
      s_rvalid <= 1'b0;
      p_rdata  <= '0;
      s_rdata  <= '0;
    end else begin
      p_rvalid <= p_valid && !p_write;
      s_rvalid <= !p_valid && s_valid && !s_write;
      if (p_valid && !p_write)               p_rdata <= rd_val;
      if (!p_valid && s_valid && !s_write)   s_rdata <= rd_val;
    end
  end

  logic [PTR_W-1:0] in_post_tail, out_free_tail;
  assign in_post_tail  = tail_a[L_IN_POST];
  assign out_free_tail = tail_a[L_OUT_FREE];

  a_r12_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_rvalid && s_rvalid));
  a_r12_host_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    p_rvalid |-> $past(p_valid && !p_write));
  a_r5_local_window_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_write && (s_addr == A_INQ || s_addr == A_OUTQ))
      |=> ($stable(in_post_tail) && $stable(out_free_tail)));
  a_r8_post_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_write && p_addr == A_INQ && !full_v[L_IN_POST] && !mask)
      |=> !s_irq_n);
endmodule

// File: tb/test_mq_doorbell_unit.sv
`timescale 1ns/1ps
module test_mq_doorbell_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_valid = 1'b0, p_write = 1'b0;
  logic [7:0]  p_addr = '0;
  logic [31:0] p_wdata = '0;
  logic        p_rvalid;
  logic [31:0] p_rdata;
  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_ready, s_rvalid;
  logic [31:0] s_rdata;
  logic        s_irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] p_exp_q[$], s_exp_q[$];
  string       p_tag_q[$], s_tag_q[$];

  always #5 clk = ~clk;

  mq_doorbell_unit i_mq_doorbell_unit (
    .clk(clk), .rst_n(rst_n),
    .p_valid(p_valid), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rvalid(p_rvalid), .p_rdata(p_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
    .s_irq_n(s_irq_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && p_rvalid) begin
      if (p_exp_q.size() == 0) chk("R12 unexpected host response", 32'd1, 32'd0);
      else chk(p_tag_q.pop_front(), p_rdata, p_exp_q.pop_front());
    end
    if (rst_n && s_rvalid) begin
      if (s_exp_q.size() == 0) chk("R12 unexpected local response", 32'd1, 32'd0);
      else chk(s_tag_q.pop_front(), s_rdata, s_exp_q.pop_front());
    end
  end

  task automatic host(bit w, logic [7:0] a, logic [31:0] d, logic [31:0] e, string tag);
    @(negedge clk);
    p_valid = 1'b1; p_write = w; p_addr = a; p_wdata = d;
    if (!w) begin p_exp_q.push_back(e); p_tag_q.push_back(tag); end
    @(posedge clk);
    @(negedge clk);
    p_valid = 1'b0;
  endtask

  task automatic local_acc(bit w, logic [7:0] a, logic [31:0] d, logic [31:0] e, string tag);
    @(negedge clk);
    s_valid = 1'b1; s_write = w; s_addr = a; s_wdata = d;
    if (!w) begin s_exp_q.push_back(e); s_tag_q.push_back(tag); end
    do @(posedge clk); while (!s_ready);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_n after reset", {31'd0, s_irq_n}, 32'd1);
    local_acc(0, 8'h3C, 0, 32'h8, "R1 R7 mask reset value");
    local_acc(0, 8'h90, 0, 32'h0, "R1 status reset");
    local_acc(0, 8'h60, 0, 32'h0, "R1 pointer reset");

    // R2 / R13: local fills inbound free list, host takes frames
    local_acc(1, 8'h80, 32'hA000_0000, 0, "");
    local_acc(1, 8'h80, 32'hA000_0100, 0, "");
    local_acc(1, 8'h80, 32'hA000_0200, 0, "");
    host(0, 8'h40, 0, 32'hA000_0000, "R2 first free frame");
    host(0, 8'h40, 0, 32'hA000_0100, "R2 second free frame");
    local_acc(0, 8'h60, 0, 32'h2, "R6 R2 free head advanced");
    host(0, 8'h40, 0, 32'hA000_0200, "R2 third free frame");
    host(0, 8'h40, 0, 32'hFFFF_FFFF, "R10 pop of empty list");
    local_acc(0, 8'h60, 0, 32'h3, "R10 head unchanged on empty pop");

    // R3 / R8: host posts, mask gates interrupt
    host(1, 8'h40, 32'hD100_0000, 0, "");
    chk("R8 masked post keeps irq high", {31'd0, s_irq_n}, 32'd1);
    local_acc(1, 8'h3C, 32'h0, 0, "");
    chk("R8 unmasked pending post drives irq low", {31'd0, s_irq_n}, 32'd0);
    local_acc(0, 8'h90, 0, 32'h10, "R11 pending bit in status");
    local_acc(0, 8'h84, 0, 32'hD100_0000, "R3 R13 local takes post");
    chk("R8 irq released after drain", {31'd0, s_irq_n}, 32'd1);

    // R4 outbound pairing
    local_acc(1, 8'h88, 32'hE100_0000, 0, "");
    host(0, 8'h44, 0, 32'hE100_0000, "R4 host reads outbound post");
    host(1, 8'h44, 32'hF100_0000, 0, "");
    local_acc(0, 8'h8C, 0, 32'hF100_0000, "R4 outbound free returned");

    // R5 local accesses to queue windows are reserved
    local_acc(1, 8'h40, 32'hDEAD_BEEF, 0, "");
    local_acc(1, 8'h44, 32'hDEAD_BEEF, 0, "");
    local_acc(0, 8'h6C, 0, 32'h1, "R5 inbound post tail unchanged");
    local_acc(0, 8'h7C, 0, 32'h1, "R5 outbound free tail unchanged");
    local_acc(0, 8'h40, 0, 32'h0, "R5 local read of inbound window");
    local_acc(0, 8'h44, 0, 32'h0, "R5 local read of outbound window");

    // R9 / R6: program pointers near the top and wrap
    local_acc(1, 8'h60, 32'hE, 0, "");
    local_acc(1, 8'h64, 32'hE, 0, "");
    local_acc(0, 8'h64, 0, 32'hE, "R6 tail pointer readback");
    for (int i = 0; i < 3; i++) local_acc(1, 8'h80, 32'hB000_0000 + i, 0, "");
    local_acc(0, 8'h64, 0, 32'h1, "R9 tail wrapped past 15");
    for (int i = 0; i < 3; i++) host(0, 8'h40, 0, 32'hB000_0000 + i, "R9 wrapped entries in order");
    local_acc(0, 8'h60, 0, 32'h1, "R9 head wrapped past 15");

    // R11: fill inbound post list, drop the 16th
    for (int i = 0; i < 16; i++) host(1, 8'h40, 32'hC000_0000 + i, 0, "");
    local_acc(0, 8'h90, 0, 32'h12, "R11 overflow flag and pending");
    local_acc(1, 8'h90, 32'h2, 0, "");
    local_acc(0, 8'h90, 0, 32'h10, "R11 overflow flag cleared");
    for (int i = 0; i < 15; i++) local_acc(0, 8'h84, 0, 32'hC000_0000 + i, "R11 R9 stored posts");
    local_acc(0, 8'h84, 0, 32'hFFFF_FFFF, "R11 dropped post absent");
    chk("R8 irq high when list empty", {31'd0, s_irq_n}, 32'd1);

    // R12: both ports at once
    @(negedge clk);
    p_valid = 1'b1; p_write = 1'b0; p_addr = 8'h44;
    s_valid = 1'b1; s_write = 1'b0; s_addr = 8'h3C;
    p_exp_q.push_back(32'hFFFF_FFFF); p_tag_q.push_back("R12 host served first");
    s_exp_q.push_back(32'h0);         s_tag_q.push_back("R12 local served after");
    #1 chk("R12 s_ready low under host request", {31'd0, s_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    p_valid = 1'b0;
    #1 chk("R12 s_ready high when host idle", {31'd0, s_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;

    // R7: only bit 3 of mask register is kept
    local_acc(1, 8'h3C, 32'hFFFF_FFFF, 0, "");
    local_acc(0, 8'h3C, 0, 32'h8, "R7 mask reserved bits read 0");
    host(1, 8'h40, 32'h1234_0000, 0, "");
    chk("R8 mask set holds irq high", {31'd0, s_irq_n}, 32'd1);

    repeat (4) @(negedge clk);
    chk("R12 all host responses seen", p_exp_q.size(), 32'd0);
    chk("R12 all local responses seen", s_exp_q.size(), 32'd0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule